// File: doc/BRIEF.md
# Complex-Sample Three-Port Memory

This block is a behavioural storage array of 256 words. Each word is a pair of signed 16-bit fields: a real part and an imaginary part. It has two independent read-only ports and one write-only port. Each port has its own latency, set through a parameter, so one instance can pair a combinational read port with a pipelined one. The write port is built either with a two-bit field mask or without one. The unmasked build ignores the mask pins and always stores the whole word.

A read port with latency N holds its address and enable for N clock stages before it looks up the array. It reports the word on the cycle its delayed enable, the port's valid flag, is high. A collision happens when a read lookup hits the address being committed in the same cycle. A parameter then decides what the read returns: the word before the write, the word after the write (with the mask applied), or unknown data. The ports apply no back-pressure: a request offered with its enable high is always accepted, and the data stream has no ready signal, so the consumer must take each word on the cycle its valid flag is high. Read data is meaningless while that port's valid flag is low.

Top module: `cmem3p`

## Requirements
- R1: The array holds 256 words, addressed by an 8-bit address. A word packs the real field in bits [15:0] and the imaginary field in bits [31:16], both signed.
- R2: A read port with latency 0 returns the addressed word in the same cycle, and its valid flag equals its enable.
- R3: A read port with latency N returns the word at the address presented N cycles earlier, and raises its valid flag N cycles after the enable.
- R4: With write latency 1, a write commits at the clock edge that samples its enable, address and data, and it is visible to a latency-0 read in the next cycle.
- R5: In the masked build, mask bit 0 enables the real field and mask bit 1 enables the imaginary field. A field whose bit is 0 keeps its stored value.
- R6: A write port whose enable is low changes no word, whatever its address, data and mask.
- R7: With the old-data policy, a colliding read returns the word as it was before the write.
- R8: With the new-data policy, a colliding read returns the word as it is after the write, with the mask applied.
- R9: In the unmasked build, an enabled write stores both fields and the mask pins have no effect.
- R10: After reset, the valid flag of every pipelined read port is low until an enable has travelled through its stages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset for the port pipelines |
| rd0_en | input | 1 | Read port 0 enable |
| rd0_addr | input | 8 | Read port 0 address |
| rd0_valid | output | 1 | Read port 0 data valid |
| rd0_re | output | 16 | Read port 0 real field |
| rd0_im | output | 16 | Read port 0 imaginary field |
| rd1_en | input | 1 | Read port 1 enable |
| rd1_addr | input | 8 | Read port 1 address |
| rd1_valid | output | 1 | Read port 1 data valid |
| rd1_re | output | 16 | Read port 1 real field |
| rd1_im | output | 16 | Read port 1 imaginary field |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 8 | Write address |
| wr_re | input | 16 | Write real field |
| wr_im | input | 16 | Write imaginary field |
| wr_mask | input | 2 | Field mask (bit 0 real, bit 1 imaginary); unused in the unmasked build |

## Verification
Two builds are driven side by side. The first is masked, has a pipelined second read port and uses the new-data policy. The second is unmasked, has two combinational read ports and uses the old-data policy. A full fill followed by a sweep that reads ascending and descending addresses at the same time shows whether every address is decoded and whether the two read ports stay independent. A sweep that cycles the four mask codes while reading the address being written separates the two collision policies, shows whether each field is masked on its own, and shows whether the unmasked build ignores the mask. Writes with the enable low, carrying garbage, then test that a disabled write leaves the array unchanged.

// File: rtl/cmem_pkg.sv
package cmem_pkg;
  localparam int FW = 16;

  typedef struct packed {
    logic signed [FW-1:0] im;
    logic signed [FW-1:0] re;
  } cword_t;

  typedef enum logic [1:0] {
    RUW_UNDEF = 2'd0,
    RUW_OLD   = 2'd1,
    RUW_NEW   = 2'd2
  } ruw_e;
endpackage

// File: rtl/cmem_rd_pipe.sv
module cmem_rd_pipe #(
  parameter int LAT = 0,
  parameter int AW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic [AW-1:0] addr_i,
  output logic          en_o,
  output logic [AW-1:0] addr_o
);
  if (LAT == 0) begin : g_comb
    logic unused_ctl;
    assign unused_ctl = clk ^ rst_n;
    assign en_o   = en_i;
    assign addr_o = addr_i;
  end else begin : g_stages
    logic [LAT-1:0]         en_q;
    logic [LAT-1:0][AW-1:0] addr_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) en_q <= '0;
      else begin
        en_q[0] <= en_i;
        for (int i = 1; i < LAT; i++) en_q[i] <= en_q[i-1];
      end
    end

    always_ff @(posedge clk) begin
      addr_q[0] <= addr_i;
      for (int i = 1; i < LAT; i++) addr_q[i] <= addr_q[i-1];
    end

    assign en_o   = en_q[LAT-1];
    assign addr_o = addr_q[LAT-1];
  end
endmodule

// File: rtl/cmem_wr_pipe.sv
module cmem_wr_pipe
  import cmem_pkg::*;
#(
  parameter int LAT    = 1,
  parameter int AW     = 8,
  parameter bit MASKED = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic [AW-1:0] addr_i,
  input  cword_t        data_i,
  input  logic [1:0]    mask_i,
  output logic          en_o,
  output logic [AW-1:0] addr_o,
  output cword_t        data_o,
  output logic [1:0]    be_o
);
  localparam int STG = (LAT > 1) ? LAT - 1 : 0;

  logic [1:0] be_in;
  if (MASKED) begin : g_mask
    assign be_in = mask_i;
  end else begin : g_full
    logic unused_mask;
    assign unused_mask = ^mask_i;
    assign be_in = 2'b11;
  end

  if (STG == 0) begin : g_direct
    logic unused_ctl;
    assign unused_ctl = clk ^ rst_n;
    assign en_o   = en_i;
    assign addr_o = addr_i;
    assign data_o = data_i;
    assign be_o   = be_in;
  end else begin : g_stages
    logic [STG-1:0]         en_q;
    logic [STG-1:0][AW-1:0] addr_q;
    cword_t                 data_q [STG];
    logic [STG-1:0][1:0]    be_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) en_q <= '0;
      else begin
        en_q[0] <= en_i;
        for (int i = 1; i < STG; i++) en_q[i] <= en_q[i-1];
      end
    end

    always_ff @(posedge clk) begin
      addr_q[0] <= addr_i;
      data_q[0] <= data_i;
      be_q[0]   <= be_in;
      for (int i = 1; i < STG; i++) begin
        addr_q[i] <= addr_q[i-1];
        data_q[i] <= data_q[i-1];
        be_q[i]   <= be_q[i-1];
      end
    end

    assign en_o   = en_q[STG-1];
    assign addr_o = addr_q[STG-1];
    assign data_o = data_q[STG-1];
    assign be_o   = be_q[STG-1];
  end
endmodule

// File: rtl/cmem_array.sv
module cmem_array
  import cmem_pkg::*;
#(
  parameter int   AW  = 8,
  parameter int   NRD = 2,
  parameter ruw_e RUW = RUW_UNDEF
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   we_i,
  input  logic [AW-1:0]          waddr_i,
  input  cword_t                 wdata_i,
  input  logic [1:0]             be_i,
  input  logic [NRD-1:0]         ren_i,
  input  logic [NRD-1:0][AW-1:0] raddr_i,
  output cword_t                 rdata_o [NRD]
);
  localparam int DEPTH = 2 ** AW;

  cword_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) begin
      if (be_i[0]) mem[waddr_i].re <= wdata_i.re;
      if (be_i[1]) mem[waddr_i].im <= wdata_i.im;
    end
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    cword_t stored, merged;
    logic   hit;

    always_comb begin
      stored    = mem[raddr_i[g]];
      merged.re = be_i[0] ? wdata_i.re : stored.re;
      merged.im = be_i[1] ? wdata_i.im : stored.im;
      hit       = we_i && (raddr_i[g] == waddr_i);
      if (!ren_i[g]) rdata_o[g] = 'x;
      else if (hit) begin
        case (RUW)
          RUW_OLD: rdata_o[g] = stored;
          RUW_NEW: rdata_o[g] = merged;
          default: rdata_o[g] = 'x;
        endcase
      end else rdata_o[g] = stored;
    end

    if (RUW == RUW_NEW) begin : g_chk_new
      // R8: colliding read shows exactly what the array holds one cycle later
      p_new_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ren_i[g] && hit |=> $past(rdata_o[g]) == mem[$past(raddr_i[g])]);
    end
    if (RUW == RUW_OLD) begin : g_chk_old
      // R7: colliding read shows the word the array held before the edge
      p_old_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ren_i[g] && hit |=> $past(rdata_o[g]) == $past(mem[raddr_i[g]]));
    end
  end

  // R4: a full-word write is stored at the sampling edge
  p_commit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    we_i && be_i == 2'b11 |=> mem[$past(waddr_i)] == $past(wdata_i));

  // R5: a masked-off real field keeps its value
  p_keep_re_r5: assert property (@(posedge clk) disable iff (!rst_n)
    we_i && !be_i[0] |=> mem[$past(waddr_i)].re == $past(mem[waddr_i].re));

  // R5: a masked-off imaginary field keeps its value
  p_keep_im_r5: assert property (@(posedge clk) disable iff (!rst_n)
    we_i && !be_i[1] |=> mem[$past(waddr_i)].im == $past(mem[waddr_i].im));
endmodule

// File: rtl/cmem3p.sv
module cmem3p
  import cmem_pkg::*;
#(
  parameter int   AW        = 8,
  parameter int   RD0_LAT   = 0,
  parameter int   RD1_LAT   = 0,
  parameter int   WR_LAT    = 1,
  parameter bit   WR_MASKED = 1'b1,
  parameter ruw_e RUW       = RUW_UNDEF
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rd0_en,
  input  logic [AW-1:0]        rd0_addr,
  output logic                 rd0_valid,
  output logic signed [FW-1:0] rd0_re,
  output logic signed [FW-1:0] rd0_im,
  input  logic                 rd1_en,
  input  logic [AW-1:0]        rd1_addr,
  output logic                 rd1_valid,
  output logic signed [FW-1:0] rd1_re,
  output logic signed [FW-1:0] rd1_im,
  input  logic                 wr_en,
  input  logic [AW-1:0]        wr_addr,
  input  logic signed [FW-1:0] wr_re,
  input  logic signed [FW-1:0] wr_im,
  input  logic [1:0]           wr_mask
);
  localparam int NRD = 2;

  logic [NRD-1:0]         en_in, en_arr;
  logic [NRD-1:0][AW-1:0] a_in, a_arr;
  cword_t                 rd_w [NRD];

  assign en_in = {rd1_en, rd0_en};
  assign a_in  = {rd1_addr, rd0_addr};

  for (genvar g = 0; g < NRD; g++) begin : g_rp
    cmem_rd_pipe #(.LAT((g == 0) ? RD0_LAT : RD1_LAT), .AW(AW)) u_rp (
      .clk(clk), .rst_n(rst_n),
      .en_i(en_in[g]), .addr_i(a_in[g]),
      .en_o(en_arr[g]), .addr_o(a_arr[g])
    );
  end

  cword_t     w_in, w_data;
  logic       w_en;
  logic [AW-1:0] w_addr;
  logic [1:0] w_be;

  assign w_in.re = wr_re;
  assign w_in.im = wr_im;

  cmem_wr_pipe #(.LAT(WR_LAT), .AW(AW), .MASKED(WR_MASKED)) u_wp (
    .clk(clk), .rst_n(rst_n),
    .en_i(wr_en), .addr_i(wr_addr), .data_i(w_in), .mask_i(wr_mask),
    .en_o(w_en), .addr_o(w_addr), .data_o(w_data), .be_o(w_be)
  );

  cmem_array #(.AW(AW), .NRD(NRD), .RUW(RUW)) u_arr (
    .clk(clk), .rst_n(rst_n),
    .we_i(w_en), .waddr_i(w_addr), .wdata_i(w_data), .be_i(w_be),
    .ren_i(en_arr), .raddr_i(a_arr), .rdata_o(rd_w)
  );

  assign rd0_valid = en_arr[0];
  assign rd1_valid = en_arr[1];
  assign rd0_re    = rd_w[0].re;
  assign rd0_im    = rd_w[0].im;
  assign rd1_re    = rd_w[1].re;
  assign rd1_im    = rd_w[1].im;

  // R9: the unmasked build stores whole words whatever the mask pins say
  if (!WR_MASKED) begin : g_chk_full
    p_full_word_r9: assert property (@(posedge clk) disable iff (!rst_n)
      w_en |-> w_be == 2'b11);
  end
endmodule

// File: tb/cmem3p_test.sv
module cmem3p_test;
  import cmem_pkg::*;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        r0e, r1e, we;
  logic [7:0]  r0a, r1a, wa;
  logic [31:0] wd;
  logic [1:0]  wm;

  logic        a_v0, a_v1, b_v0, b_v1;
  logic [15:0] a_r0re, a_r0im, a_r1re, a_r1im, b_r0re, b_r0im, b_r1re, b_r1im;

  // masked, port 1 pipelined by one stage, new-data policy
  cmem3p #(.RD1_LAT(1), .RUW(RUW_NEW)) uut (
    .clk(clk), .rst_n(rst_n),
    .rd0_en(r0e), .rd0_addr(r0a), .rd0_valid(a_v0), .rd0_re(a_r0re), .rd0_im(a_r0im),
    .rd1_en(r1e), .rd1_addr(r1a), .rd1_valid(a_v1), .rd1_re(a_r1re), .rd1_im(a_r1im),
    .wr_en(we), .wr_addr(wa), .wr_re(wd[15:0]), .wr_im(wd[31:16]), .wr_mask(wm)
  );

  // unmasked, both ports combinational, old-data policy
  cmem3p #(.WR_MASKED(1'b0), .RUW(RUW_OLD)) uut_flat (
    .clk(clk), .rst_n(rst_n),
    .rd0_en(r0e), .rd0_addr(r0a), .rd0_valid(b_v0), .rd0_re(b_r0re), .rd0_im(b_r0im),
    .rd1_en(r1e), .rd1_addr(r1a), .rd1_valid(b_v1), .rd1_re(b_r1re), .rd1_im(b_r1im),
    .wr_en(we), .wr_addr(wa), .wr_re(wd[15:0]), .wr_im(wd[31:16]), .wr_mask(wm)
  );

  logic [31:0] m_a [256];
  logic [31:0] m_b [256];
  logic        p1e = 1'b0;
  logic [7:0]  p1a = '0;
  int n_run = 0, n_fail = 0;

  function automatic logic [31:0] mrg(logic [31:0] old, logic [31:0] nw, logic [1:0] m);
    return {m[1] ? nw[31:16] : old[31:16], m[0] ? nw[15:0] : old[15:0]};
  endfunction

  function automatic logic [31:0] pat(int a, int k);
    logic [15:0] re, im;
    re = 16'(a * 37 + 5 + k * 1000);
    im = 16'(-(a * 3) - 1 - k * 77);
    return {im, re};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(string t0, string t1, string tf,
                     logic e0, logic [7:0] a0, logic e1, logic [7:0] a1,
                     logic w, logic [7:0] wadr, logic [31:0] wdat, logic [1:0] wmsk);
    logic [31:0] ex;
    @(negedge clk);
    r0e = e0; r0a = a0; r1e = e1; r1a = a1;
    we = w; wa = wadr; wd = wdat; wm = wmsk;
    #1;
    chk(t0, {31'd0, a_v0}, {31'd0, e0});
    if (e0) begin
      ex = (w && wadr == a0) ? mrg(m_a[a0], wdat, wmsk) : m_a[a0];
      chk(t0, {a_r0im, a_r0re}, ex);
    end
    chk(t1, {31'd0, a_v1}, {31'd0, p1e});
    if (p1e) begin
      ex = (w && wadr == p1a) ? mrg(m_a[p1a], wdat, wmsk) : m_a[p1a];
      chk(t1, {a_r1im, a_r1re}, ex);
    end
    if (e0) chk(tf, {b_r0im, b_r0re}, m_b[a0]);
    if (e1) chk(tf, {b_r1im, b_r1re}, m_b[a1]);
    if (w) begin
      m_a[wadr] = mrg(m_a[wadr], wdat, wmsk);
      m_b[wadr] = wdat;
    end
    p1e = e1; p1a = a1;
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    r0e = 0; r1e = 0; we = 0; r0a = 0; r1a = 0; wa = 0; wd = 0; wm = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R10: pipelined port not valid after reset
    chk("R10", {31'd0, a_v1}, 32'd0);
    // fill every address, full mask (R1, R4)
    for (int a = 0; a < 256; a++) cyc("R4", "R3", "R9", 0, 0, 0, 0, 1, 8'(a), pat(a, 0), 2'b11);
    // ascending and descending readback on both ports (R1, R2, R3)
    for (int a = 0; a < 256; a++) cyc("R1", "R3", "R1", 1, 8'(a), 1, 8'(255 - a), 0, 0, 0, 0);
    // mask sweep with same-address reads (R5, R7, R8, R9)
    for (int a = 0; a < 64; a++) cyc("R8", "R5", "R7", 1, 8'(a), 1, 8'(a), 1, 8'(a), pat(a, 1), 2'(a % 4));
    // R9: whole word stored in unmasked build even with mask 0
    cyc("R2", "R3", "R9", 1, 8'd100, 0, 0, 1, 8'd100, pat(100, 2), 2'b00);
    cyc("R5", "R3", "R9", 1, 8'd100, 1, 8'd100, 0, 0, 0, 0);
    // R6: disabled writes with garbage change nothing
    for (int a = 0; a < 32; a++) cyc("R6", "R3", "R6", 0, 0, 0, 0, 0, 8'(a * 8), 32'hDEAD_BEEF, 2'b11);
    for (int a = 0; a < 32; a++) cyc("R6", "R6", "R6", 1, 8'(a * 8), 1, 8'(a * 8 + 1), 0, 0, 0, 0);
    // R3: enable gap then valid must drop on the pipelined port
    cyc("R2", "R3", "R1", 1, 8'd7, 0, 0, 0, 0, 0, 0);
    cyc("R2", "R3", "R1", 1, 8'd8, 0, 0, 0, 0, 0, 0);
    // final full readback (R1, R4)
    for (int a = 0; a < 256; a++) cyc("R4", "R3", "R1", 1, 8'(a), 1, 8'(a ^ 8'h5A), 0, 0, 0, 0);
    cyc("R2", "R3", "R1", 0, 0, 0, 0, 0, 0, 0, 0);
    finish_run();
  end
endmodule